// File: doc/BRIEF.md
# Multichannel DAC Double-Buffered Register Bank

This block is the digital register core behind a sixteen-channel digital-to-analog converter. A serial front end drives it through a plain address, data and write-strobe bus, plus a read strobe. Each channel keeps two 16-bit registers. The staging (buffer) register takes host writes. The live (active) register feeds the converter with an unsigned straight-binary code, whatever output range is selected.

Each channel is set to one of two modes, one configuration bit per channel:

- **Immediate mode:** a write reaches the live register at once.
- **Triggered mode:** a write waits in the staging register until a one-cycle trigger pulse. That pulse updates every triggered-mode channel in the same edge.

A broadcast data register loads one value into both registers of every channel whose broadcast-enable bit is set. It does this in one step and in either mode. Full-scale gain (1x or 2x) is set per group of four channels. The per-channel short-detect inputs are readable live, and a global flag reports whether any of them is asserted.

Top module: `dac_bank_core`

## Requirements
- R1: While rst_ni is low, and after it is released, every live code, every staging register, every gain bit, the trigger-mode register and the broadcast-enable register read as zero. Every channel is therefore in immediate mode with 1x gain.
- R2: A write with addr_i = c, for c in 0..15, to an immediate-mode channel puts wdata_i into that channel's staging register. In the same clock edge it also puts wdata_i into the channel's live code `code_o[16c +: 16]`. No other channel changes.
- R3: A write to a triggered-mode channel changes only its staging register, and its live code holds. At the rising edge where trig_i is high, every triggered-mode channel copies its staging value into its live code.
- R4: trig_i leaves immediate-mode channels unchanged. A trigger on a triggered-mode channel whose staging and live values already match leaves the live code unchanged.
- R5: A write to the broadcast data address (0x13) loads wdata_i into the staging and live registers of every channel whose bit is set in the broadcast-enable register (address 0x12, bit c = channel c). This happens in that edge and in either mode. Channels that are not enabled are untouched.
- R6: When a broadcast write and trig_i fall in the same cycle, enabled channels take the broadcast value. Triggered-mode channels that are not enabled take their staging value.
- R7: Gain register bit g (address 0x10, bits 3:0) drives gain_o for channels 4g to 4g+3, so all four channels of a group share one setting. gain_o changes only on a write to 0x10.
- R8: short_any_o is high exactly when at least one bit of short_i is high, with no register in between. A read of 0x14 returns short_i live, and a read of 0x15 returns short_any_o in bit 0.
- R9: Reads have one cycle of latency. rdata_o holds, after the edge where rd_en_i is sampled, the value at addr_i:
  - addresses 0x00 to 0x0F return the channel's staging value;
  - 0x10 returns gain, 0x11 the trigger-mode register (bit c = 1 puts channel c in triggered mode), and 0x12 broadcast enable;
  - every other address returns zero.
- R10: When a write and trig_i reach a triggered-mode channel in the same cycle, the live code takes the staging value from before the write. The new value stays pending for the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, one cycle after rd_en_i |
| trig_i | input | 1 | Single-cycle transfer trigger |
| short_i | input | 16 | Per-channel short-detect inputs |
| code_o | output | 256 | Live codes, channel c at bits 16c+15:16c |
| gain_o | output | 16 | Per-channel gain select (0 = 1x, 1 = 2x) |
| short_any_o | output | 1 | OR of all short-detect inputs |

## Verification
The bench aims at the cycles where two update sources meet:

- **Broadcast and trigger together.** A bank that let the trigger win would overwrite an enabled channel with its stale staging value.
- **Write and trigger together.** A bank that forwarded the new word would show it one trigger early.

Triggered-mode writes are checked for a live code that moves too soon, and repeated triggers for codes that drift. Broadcasts to a mix of enabled and disabled channels are checked for any spill onto the disabled ones. The quad gain mapping and the live short-circuit reads are checked against fixed patterns, which exposes a swapped group or a latched status.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int unsigned ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_GAIN  = 5'h10;
  localparam logic [ADDR_W-1:0] A_SYNC  = 5'h11;
  localparam logic [ADDR_W-1:0] A_BCEN  = 5'h12;
  localparam logic [ADDR_W-1:0] A_BCDAT = 5'h13;
  localparam logic [ADDR_W-1:0] A_SHORT = 5'h14;
  localparam logic [ADDR_W-1:0] A_ANY   = 5'h15;
endpackage

// File: rtl/dac_bank_chan.sv
module dac_bank_chan #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          sync_i,
  input  logic          trig_i,
  input  logic          bc_i,
  output logic [DW-1:0] buf_o,
  output logic [DW-1:0] act_o
);
  logic [DW-1:0] buf_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else if (bc_i) begin
      // broadcast owns both stages and beats trigger
      buf_q <= wdata_i;
      act_q <= wdata_i;
    end else begin
      if (wr_i) buf_q <= wdata_i;
      if (wr_i && !sync_i)      act_q <= wdata_i;
      else if (sync_i && trig_i) act_q <= buf_q;
    end
  end

  assign buf_o = buf_q;
  assign act_o = act_q;
endmodule

// File: rtl/dac_bank_cfg.sv
module dac_bank_cfg
  import dac_bank_pkg::*;
#(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned N_GRP = 4,
  parameter int unsigned DW    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [N_GRP-1:0]  gain_q_o,
  output logic [N_CH-1:0]   sync_q_o,
  output logic [N_CH-1:0]   bcen_q_o,
  output logic [N_CH-1:0]   ch_wr_o,
  output logic [N_CH-1:0]   ch_bc_o,
  output logic [N_CH-1:0]   gain_o
);
  localparam int unsigned GS = N_CH / N_GRP;

  logic [N_GRP-1:0] gain_q;
  logic [N_CH-1:0]  sync_q, bcen_q;
  logic             bc_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_q <= '0;
      sync_q <= '0;
      bcen_q <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_GAIN:  gain_q <= wdata_i[N_GRP-1:0];
        A_SYNC:  sync_q <= wdata_i[N_CH-1:0];
        A_BCEN:  bcen_q <= wdata_i[N_CH-1:0];
        default: ;
      endcase
    end
  end

  assign bc_wr = wr_en_i && (addr_i == A_BCDAT);

  for (genvar c = 0; c < N_CH; c++) begin : g_dec
    assign ch_wr_o[c] = wr_en_i && (addr_i == ADDR_W'(c));
    assign ch_bc_o[c] = bc_wr && bcen_q[c];
    assign gain_o[c]  = gain_q[c / GS];
  end

  assign gain_q_o = gain_q;
  assign sync_q_o = sync_q;
  assign bcen_q_o = bcen_q;
endmodule

// File: rtl/dac_bank_rd.sv
module dac_bank_rd
  import dac_bank_pkg::*;
#(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned N_GRP = 4,
  parameter int unsigned DW    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [N_CH*DW-1:0] buf_i,
  input  logic [N_GRP-1:0]   gain_q_i,
  input  logic [N_CH-1:0]    sync_q_i,
  input  logic [N_CH-1:0]    bcen_q_i,
  input  logic [N_CH-1:0]    short_i,
  output logic [DW-1:0]      rdata_o,
  output logic               short_any_o
);
  logic [DW-1:0] mux;
  logic          any;

  assign any = |short_i;

  always_comb begin
    mux = '0;
    if (addr_i < ADDR_W'(N_CH)) begin
      for (int c = 0; c < N_CH; c++)
        if (addr_i == ADDR_W'(c)) mux = buf_i[c*DW +: DW];
    end else begin
      case (addr_i)
        A_GAIN:  mux[N_GRP-1:0] = gain_q_i;
        A_SYNC:  mux[N_CH-1:0]  = sync_q_i;
        A_BCEN:  mux[N_CH-1:0]  = bcen_q_i;
        A_SHORT: mux[N_CH-1:0]  = short_i;
        A_ANY:   mux[0]         = any;
        default: mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mux;
  end

  assign short_any_o = any;
endmodule

// File: rtl/dac_bank_core.sv
module dac_bank_core
  import dac_bank_pkg::*;
#(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned N_GRP = 4,
  parameter int unsigned DW    = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  input  logic               trig_i,
  input  logic [N_CH-1:0]    short_i,
  output logic [N_CH*DW-1:0] code_o,
  output logic [N_CH-1:0]    gain_o,
  output logic               short_any_o
);
  logic [N_GRP-1:0]   gain_q;
  logic [N_CH-1:0]    sync_q, bcen_q, ch_wr, ch_bc;
  logic [N_CH*DW-1:0] buf_flat;

  dac_bank_cfg #(.N_CH(N_CH), .N_GRP(N_GRP), .DW(DW)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .gain_q_o (gain_q),
    .sync_q_o (sync_q),
    .bcen_q_o (bcen_q),
    .ch_wr_o  (ch_wr),
    .ch_bc_o  (ch_bc),
    .gain_o   (gain_o)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dac_bank_chan #(.DW(DW)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (ch_wr[c]),
      .wdata_i (wdata_i),
      .sync_i  (sync_q[c]),
      .trig_i  (trig_i),
      .bc_i    (ch_bc[c]),
      .buf_o   (buf_flat[c*DW +: DW]),
      .act_o   (code_o[c*DW +: DW])
    );
  end

  dac_bank_rd #(.N_CH(N_CH), .N_GRP(N_GRP), .DW(DW)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_i),
    .addr_i      (addr_i),
    .buf_i       (buf_flat),
    .gain_q_i    (gain_q),
    .sync_q_i    (sync_q),
    .bcen_q_i    (bcen_q),
    .short_i     (short_i),
    .rdata_o     (rdata_o),
    .short_any_o (short_any_o)
  );
endmodule

// File: rtl/dac_bank_core_chk.sv
module dac_bank_core_chk
  import dac_bank_pkg::*;
#(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned N_GRP = 4,
  parameter int unsigned DW    = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DW-1:0]      wdata_i,
  input logic               trig_i,
  input logic [N_CH-1:0]    short_i,
  input logic [N_CH*DW-1:0] code_o,
  input logic [N_CH-1:0]    gain_o,
  input logic               short_any_o,
  input logic [N_CH-1:0]    sync_q,
  input logic [N_CH-1:0]    bcen_q
);
  localparam int unsigned GS = N_CH / N_GRP;

  logic bc_hit;
  assign bc_hit = wr_en_i && (addr_i == A_BCDAT);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assert_imm_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(c) && !sync_q[c]) |=> code_o[c*DW +: DW] == $past(wdata_i));

    assert_sync_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_q[c] && !trig_i && !(bc_hit && bcen_q[c])) |=> $stable(code_o[c*DW +: DW]));

    assert_imm_no_trig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sync_q[c] && !(wr_en_i && addr_i == ADDR_W'(c)) && !(bc_hit && bcen_q[c]))
        |=> $stable(code_o[c*DW +: DW]));

    assert_bcast_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bc_hit && bcen_q[c]) |=> code_o[c*DW +: DW] == $past(wdata_i));
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assert_gain_group_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gain_o[g*GS +: GS] == '0) || (gain_o[g*GS +: GS] == '1));
  end

  assert_gain_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_GAIN) |=> $stable(gain_o));

  assert_any_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_i == '0) |-> !short_any_o);

  assert_any_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_i != '0) |-> short_any_o);
endmodule

bind dac_bank_core dac_bank_core_chk #(.N_CH(N_CH), .N_GRP(N_GRP), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .trig_i      (trig_i),
  .short_i     (short_i),
  .code_o      (code_o),
  .gain_o      (gain_o),
  .short_any_o (short_any_o),
  .sync_q      (sync_q),
  .bcen_q      (bcen_q)
);

// File: tb/dac_bank_core_bench.sv
module dac_bank_core_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic         rd_en_i = 1'b0;
  logic [4:0]   addr_i = '0;
  logic [15:0]  wdata_i = '0;
  logic [15:0]  rdata_o;
  logic         trig_i = 1'b0;
  logic [15:0]  short_i = '0;
  logic [255:0] code_o;
  logic [15:0]  gain_o;
  logic         short_any_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  dac_bank_core u_dac_bank_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .trig_i(trig_i),
    .short_i(short_i), .code_o(code_o), .gain_o(gain_o), .short_any_o(short_any_o)
  );

  function automatic logic [15:0] code(input int c);
    return code_o[c*16 +: 16];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic tg);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; trig_i = tg;
    @(negedge clk_i);
    wr_en_i = 1'b0; trig_i = 1'b0;
  endtask

  task automatic trig();
    @(negedge clk_i);
    trig_i = 1'b1;
    @(negedge clk_i);
    trig_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int c = 0; c < 16; c++) check("R1 code", code(c), 16'h0);
    check("R1 gain", gain_o, 16'h0);
    rd(5'h11, d); check("R1 sync cfg", d, 16'h0);
    rd(5'h12, d); check("R1 bcast en", d, 16'h0);
    rd(5'h07, d); check("R1 staging", d, 16'h0);
  endtask

  task automatic t_async();
    wr(5'd3, 16'hA5A5, 1'b0);
    check("R2 ch3 live", code(3), 16'hA5A5);
    check("R2 ch2 untouched", code(2), 16'h0);
    wr(5'd15, 16'hFFFF, 1'b0);
    check("R2 ch15 live", code(15), 16'hFFFF);
    check("R2 ch14 untouched", code(14), 16'h0);
  endtask

  task automatic t_sync();
    logic [15:0] d;
    wr(5'h11, 16'h0060, 1'b0);          // ch5, ch6 triggered
    wr(5'd5, 16'h1234, 1'b0);
    check("R3 ch5 holds before trigger", code(5), 16'h0);
    rd(5'd5, d); check("R9 staging read ch5", d, 16'h1234);
    trig();
    check("R3 ch5 after trigger", code(5), 16'h1234);
    check("R4 ch3 immediate ignores trigger", code(3), 16'hA5A5);
    trig();
    check("R4 ch5 repeat trigger", code(5), 16'h1234);
  endtask

  task automatic t_wr_trig();
    wr(5'd6, 16'h1111, 1'b0);
    trig();
    check("R3 ch6 after trigger", code(6), 16'h1111);
    wr(5'd6, 16'h2222, 1'b1);
    check("R10 ch6 takes old staging", code(6), 16'h1111);
    trig();
    check("R10 ch6 pending applied", code(6), 16'h2222);
  endtask

  task automatic t_bcast();
    logic [15:0] d;
    wr(5'h12, 16'h0221, 1'b0);          // ch0, ch5, ch9
    wr(5'h13, 16'hBEEF, 1'b0);
    check("R5 ch0", code(0), 16'hBEEF);
    check("R5 ch5 triggered mode", code(5), 16'hBEEF);
    check("R5 ch9", code(9), 16'hBEEF);
    check("R5 ch3 not enabled", code(3), 16'hA5A5);
    check("R5 ch6 not enabled", code(6), 16'h2222);
    rd(5'd5, d); check("R5 ch5 staging", d, 16'hBEEF);
  endtask

  task automatic t_bcast_trig();
    wr(5'd5, 16'h4444, 1'b0);
    wr(5'd6, 16'h3333, 1'b0);
    check("R3 ch6 pending", code(6), 16'h2222);
    wr(5'h13, 16'h5555, 1'b1);
    check("R6 ch5 broadcast wins", code(5), 16'h5555);
    check("R6 ch6 trigger applies", code(6), 16'h3333);
    check("R6 ch0 broadcast", code(0), 16'h5555);
  endtask

  task automatic t_gain();
    logic [15:0] d;
    wr(5'h10, 16'h000A, 1'b0);
    check("R7 gain map", gain_o, 16'hF0F0);
    wr(5'd1, 16'h0001, 1'b0);
    check("R7 gain stable", gain_o, 16'hF0F0);
    rd(5'h10, d); check("R9 gain read", d, 16'h000A);
    rd(5'h11, d); check("R9 sync read", d, 16'h0060);
    rd(5'h1F, d); check("R9 unmapped read", d, 16'h0000);
  endtask

  task automatic t_short();
    logic [15:0] d;
    @(negedge clk_i); short_i = 16'h0000; #1;
    check("R8 any clear", short_any_o, 1'b0);
    short_i = 16'h0100; #1;
    check("R8 any set", short_any_o, 1'b1);
    rd(5'h14, d); check("R8 status live", d, 16'h0100);
    rd(5'h15, d); check("R8 global read", d, 16'h0001);
    @(negedge clk_i); short_i = 16'h8001;
    rd(5'h14, d); check("R8 status follows", d, 16'h8001);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i); rst_ni = 1'b1;
    t_reset();
    t_async();
    t_sync();
    t_wr_trig();
    t_bcast();
    t_bcast_trig();
    t_gain();
    t_short();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule